// File: doc/BRIEF.md
# DMA Control-Block Chain Walker

This block follows a chain of DMA control blocks held in memory on behalf of one channel. It fetches each control block one 64-bit word at a time: the link to the following block, an information word, and then a status word and a data pointer for every data block the block describes. For each data block that is ready, it presents the block's address, its byte length and the control block's information word to a data mover through a valid/ready stream. The data copy itself is not done here.

The walker enforces the placement rules. Control blocks must sit on 8-byte boundaries. In extraction mode, every data block must also start on an 8-byte boundary and have a length that is a whole multiple of 128 bytes. A rule violation stops the walk and holds an error flag. A one-cycle completion interrupt marks each finished control block. A separate update interrupt tells software that the chain needs attention, either because the chain ended or because a data block's status word is still marked used. A restart pulse then resumes the walk at the point where it stopped.

Top module: `dlw_walker`

## Requirements
- R1: After reset, no memory request or block is offered, both interrupt outputs are low and the error flag is low.
- R2: A control block at address A is read as word A (link), A+8 (information), then A+16+16k (status) and A+24+16k (pointer) for data block k in order. Only one read is outstanding. A request holds its address until accepted, and the next request is issued only after the previous response.
- R3: Each data block is offered with address equal to the low 32 bits of its pointer word, length equal to status bits [15:0] and info equal to the low 32 bits of the information word, in chain order. The values stay stable while the consumer stalls.
- R4: The number of data blocks per control block is sampled from the configuration input when a walk starts. A value of 0 means a control block carries only its link and information words.
- R5: The completion interrupt pulses for one cycle after the last data block of each control block is accepted, or after the information word when the count is 0.
- R6: A link word of all ones ends the chain. After that control block completes, the walker raises the update interrupt for one cycle and waits. A restart pulse re-reads the link word of the same control block and follows it if it is no longer the end mark.
- R7: A status word with bit 63 set stops the walk before its block is offered and pulses the update interrupt. A restart pulse re-reads that same status word.
- R8: A start address or link address whose bits [2:0] are not zero raises the error flag instead of any read of that address. The flag stays high until a new start pulse.
- R9: When the extraction input is high at start, a data pointer with nonzero bits [2:0] or a length with nonzero bits [6:0] raises the error flag and the block is not offered. In injection mode, neither rule applies.
- R10: A start pulse while a walk is in progress (not idle, waiting or in error) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse when idle or in error; resume pulse when waiting |
| start_addr_i | input | 32 | Address of the first control block |
| nblk_cfg_i | input | 4 | Data blocks per control block |
| extract_i | input | 1 | 1 selects the extraction placement rules |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Byte address of the 64-bit word to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data |
| blk_valid_o | output | 1 | Data block descriptor valid |
| blk_ready_i | input | 1 | Data mover takes the descriptor |
| blk_addr_o | output | 32 | Data block address |
| blk_len_o | output | 16 | Data block length in bytes |
| blk_info_o | output | 32 | Information word of the owning control block |
| irq_done_o | output | 1 | Control block completed (pulse) |
| irq_update_o | output | 1 | Chain needs a software update (pulse) |
| err_o | output | 1 | Placement rule violated, walk stopped |

## Verification
The walker is tried on two linked control blocks with two data blocks each, under an irregular consumer stall. This exposes errors in read order, field extraction and hand-over stability. Later patterns append a block to the chain and restart, stall on a used status word and resume, and follow a misaligned link. Together these separate the end-of-chain restart from the status-word restart, and show that neither re-offers earlier blocks. Extraction-mode runs with a bad length, a bad pointer and a fully legal three-block list set the placement rules apart from injection mode. Runs with a zero block count, a misaligned start address and a start pulse during a walk cover the remaining corners.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_RESP, ST_EMIT, ST_HOP, ST_WAIT, ST_ERR
  } dlw_state_e;

  typedef enum logic [2:0] {
    RD_LINK, RD_INFO, RD_STAT, RD_PTR, RD_RELINK
  } dlw_rd_e;

  localparam int unsigned WORD_BITS  = 64;
  localparam int unsigned USED_BIT   = 63;
  localparam int unsigned ALIGN_BITS = 3;
  localparam int unsigned CHUNK_BITS = 7;
  localparam logic [WORD_BITS-1:0] END_MARK = '1;
endpackage

// File: rtl/dlw_memrd.sv
module dlw_memrd #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  output logic          done_o
);
  logic          vld_q, vld_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    vld_d   = vld_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    done_o  = 1'b0;
    if (issue_i) begin
      vld_d   = 1'b1;
      addr_d  = addr_i;
      addr_en = 1'b1;
    end else if (vld_q && req_ready_i) begin
      vld_d  = 1'b0;
      pend_d = 1'b1;
    end
    if (pend_q && rsp_valid_i) begin
      pend_d = 1'b0;
      done_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      pend_q <= pend_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign req_valid_o = vld_q;
  assign req_addr_o  = addr_q;
endmodule

// File: rtl/dlw_rules.sv
module dlw_rules #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          extract_i,
  input  logic [AW-1:0] cb_addr_i,
  input  logic [AW-1:0] blk_ptr_i,
  input  logic [LW-1:0] blk_len_i,
  output logic          cb_bad_o,
  output logic          blk_bad_o
);
  import dlw_pkg::*;

  assign cb_bad_o  = |cb_addr_i[ALIGN_BITS-1:0];
  assign blk_bad_o = extract_i &&
                     ((|blk_ptr_i[ALIGN_BITS-1:0]) || (|blk_len_i[CHUNK_BITS-1:0]));
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LW     = 16,
  parameter int unsigned IW     = 32,
  parameter int unsigned MAXBLK = 15,
  localparam int unsigned CW    = $clog2(MAXBLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] nblk_cfg_i,
  input  logic          extract_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [63:0]   mem_rsp_data_i,
  output logic          blk_valid_o,
  input  logic          blk_ready_i,
  output logic [AW-1:0] blk_addr_o,
  output logic [LW-1:0] blk_len_o,
  output logic [IW-1:0] blk_info_o,
  output logic          irq_done_o,
  output logic          irq_update_o,
  output logic          err_o
);
  import dlw_pkg::*;

  dlw_state_e    state_q, state_d;
  dlw_rd_e       kind_q, kind_d;
  logic [AW-1:0] cb_q, cb_d, link_q, link_d, ptr_q, ptr_d;
  logic          eol_q, eol_d, extr_q, extr_d;
  logic [IW-1:0] info_q, info_d;
  logic [LW-1:0] len_q, len_d;
  logic [CW-1:0] idx_q, idx_d, nblk_q, nblk_d;
  logic          done_q, done_d, upd_q, upd_d;
  logic          issue, rd_done, cb_bad, blk_bad, cb_end;
  logic [AW-1:0] rd_addr, pair_off, cb_check;

  assign pair_off = AW'({idx_q, 4'b0000});

  always_comb begin
    case (kind_q)
      RD_INFO: rd_addr = cb_q + AW'(8);
      RD_STAT: rd_addr = cb_q + AW'(16) + pair_off;
      RD_PTR:  rd_addr = cb_q + AW'(24) + pair_off;
      default: rd_addr = cb_q;
    endcase
  end

  assign cb_check = (state_q == ST_HOP) ? link_q : start_addr_i;

  dlw_memrd #(.AW(AW)) rd_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .addr_i(rd_addr),
    .req_valid_o(mem_req_valid_o), .req_ready_i(mem_req_ready_i),
    .req_addr_o(mem_req_addr_o), .rsp_valid_i(mem_rsp_valid_i), .done_o(rd_done)
  );

  dlw_rules #(.AW(AW), .LW(LW)) rules_i (
    .extract_i(extr_q), .cb_addr_i(cb_check),
    .blk_ptr_i(mem_rsp_data_i[AW-1:0]), .blk_len_i(len_q),
    .cb_bad_o(cb_bad), .blk_bad_o(blk_bad)
  );

  always_comb begin
    state_d = state_q;  kind_d = kind_q;  cb_d = cb_q;    link_d = link_q;
    ptr_d   = ptr_q;    eol_d  = eol_q;   extr_d = extr_q; info_d = info_q;
    len_d   = len_q;    idx_d  = idx_q;   nblk_d = nblk_q;
    done_d  = 1'b0;     upd_d  = 1'b0;    issue  = 1'b0;   cb_end = 1'b0;
    case (state_q)
      ST_IDLE, ST_ERR: if (start_i) begin
        nblk_d = nblk_cfg_i;
        extr_d = extract_i;
        idx_d  = '0;
        if (cb_bad) state_d = ST_ERR;
        else begin
          cb_d    = start_addr_i;
          kind_d  = RD_LINK;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        issue   = 1'b1;
        state_d = ST_RESP;
      end
      ST_RESP: if (rd_done) begin
        case (kind_q)
          RD_LINK: begin
            eol_d   = (mem_rsp_data_i == END_MARK);
            link_d  = mem_rsp_data_i[AW-1:0];
            kind_d  = RD_INFO;
            state_d = ST_ISSUE;
          end
          RD_INFO: begin
            info_d = mem_rsp_data_i[IW-1:0];
            idx_d  = '0;
            if (nblk_q == '0) cb_end = 1'b1;
            else begin
              kind_d  = RD_STAT;
              state_d = ST_ISSUE;
            end
          end
          RD_STAT: begin
            if (mem_rsp_data_i[USED_BIT]) begin
              upd_d   = 1'b1;
              state_d = ST_WAIT;
            end else begin
              len_d   = mem_rsp_data_i[LW-1:0];
              kind_d  = RD_PTR;
              state_d = ST_ISSUE;
            end
          end
          RD_PTR: begin
            ptr_d   = mem_rsp_data_i[AW-1:0];
            state_d = blk_bad ? ST_ERR : ST_EMIT;
          end
          default: begin
            if (mem_rsp_data_i == END_MARK) begin
              upd_d   = 1'b1;
              state_d = ST_WAIT;
            end else begin
              link_d  = mem_rsp_data_i[AW-1:0];
              state_d = ST_HOP;
            end
          end
        endcase
      end
      ST_EMIT: if (blk_ready_i) begin
        if (idx_q + CW'(1) == nblk_q) cb_end = 1'b1;
        else begin
          idx_d   = idx_q + CW'(1);
          kind_d  = RD_STAT;
          state_d = ST_ISSUE;
        end
      end
      ST_HOP: begin
        if (cb_bad) state_d = ST_ERR;
        else begin
          cb_d    = link_q;
          idx_d   = '0;
          kind_d  = RD_LINK;
          state_d = ST_ISSUE;
        end
      end
      ST_WAIT: if (start_i) state_d = ST_ISSUE;
      default: state_d = ST_IDLE;
    endcase
    if (cb_end) begin
      done_d = 1'b1;
      if (eol_q) begin
        upd_d   = 1'b1;
        kind_d  = RD_RELINK;
        state_d = ST_WAIT;
      end else begin
        state_d = ST_HOP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  kind_q <= RD_LINK;  cb_q <= '0;   link_q <= '0;
      ptr_q   <= '0;       eol_q  <= 1'b0;     extr_q <= 1'b0; info_q <= '0;
      len_q   <= '0;       idx_q  <= '0;       nblk_q <= '0;
      done_q  <= 1'b0;     upd_q  <= 1'b0;
    end else begin
      state_q <= state_d;  kind_q <= kind_d;   cb_q <= cb_d;  link_q <= link_d;
      ptr_q   <= ptr_d;    eol_q  <= eol_d;    extr_q <= extr_d; info_q <= info_d;
      len_q   <= len_d;    idx_q  <= idx_d;    nblk_q <= nblk_d;
      done_q  <= done_d;   upd_q  <= upd_d;
    end
  end

  assign blk_valid_o  = (state_q == ST_EMIT);
  assign blk_addr_o   = ptr_q;
  assign blk_len_o    = len_q;
  assign blk_info_o   = info_q;
  assign irq_done_o   = done_q;
  assign irq_update_o = upd_q;
  assign err_o        = (state_q == ST_ERR);
endmodule

// File: rtl/dlw_walker_chk.sv
module dlw_walker_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_rsp_valid_i,
  input logic          blk_valid_o,
  input logic          blk_ready_i,
  input logic [AW-1:0] blk_addr_o,
  input logic [LW-1:0] blk_len_o,
  input logic [IW-1:0] blk_info_o,
  input logic          irq_done_o,
  input logic          irq_update_o,
  input logic          err_o
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) outst_q <= 1'b1;
    else if (mem_rsp_valid_i) outst_q <= 1'b0;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_valid_o);

  assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000);

  assert_blk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o && !blk_ready_i |=> blk_valid_o && $stable(blk_addr_o)
      && $stable(blk_len_o) && $stable(blk_info_o));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done_o |=> !irq_done_o);

  assert_update_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update_o |=> !irq_update_o);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !mem_req_valid_o && !blk_valid_o);
endmodule

bind dlw_walker dlw_walker_chk #(.AW(AW), .LW(LW), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
  .blk_valid_o(blk_valid_o), .blk_ready_i(blk_ready_i),
  .blk_addr_o(blk_addr_o), .blk_len_o(blk_len_o), .blk_info_o(blk_info_o),
  .irq_done_o(irq_done_o), .irq_update_o(irq_update_o), .err_o(err_o)
);

// File: tb/dlw_walker_tb.sv
module dlw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [3:0]  nblk_cfg_i = '0;
  logic        extract_i = 1'b0;
  logic        mem_req_valid_o, mem_req_ready_i;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        blk_valid_o, blk_ready_i;
  logic [31:0] blk_addr_o;
  logic [15:0] blk_len_o;
  logic [31:0] blk_info_o;
  logic        irq_done_o, irq_update_o, err_o;

  localparam logic [63:0] EOL  = '1;
  localparam logic [63:0] USED = 64'h8000_0000_0000_0000;

  dlw_walker dut_i (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0, upd_cnt = 0;
  bit bp_en = 1'b0;
  logic [63:0] mem [logic [31:0]];
  logic [79:0] exp_q [$];
  logic [31:0] req_log [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle response to each accepted request
  assign mem_req_ready_i = 1'b1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid_o && mem_req_ready_i) begin
      mem_rsp_valid_i <= 1'b1;
      mem_rsp_data_i  <= mem.exists(mem_req_addr_o) ? mem[mem_req_addr_o] : 64'h0;
    end else begin
      mem_rsp_valid_i <= 1'b0;
    end
  end

  // consumer ready pattern, changed just after the edge
  always @(posedge clk) begin
    #1 blk_ready_i = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor: pops expected blocks and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_done_o) done_cnt++;
      if (irq_update_o) upd_cnt++;
      if (mem_req_valid_o && mem_req_ready_i) req_log.push_back(mem_req_addr_o);
      if (blk_valid_o && blk_ready_i) begin
        if (exp_q.size() == 0)
          check(1'b0, "R3", "unexpected block", {blk_info_o, blk_len_o, blk_addr_o}, 80'h0);
        else begin
          logic [79:0] e;
          e = exp_q.pop_front();
          check({blk_info_o, blk_len_o, blk_addr_o} == e, "R3", "block fields",
                {blk_info_o, blk_len_o, blk_addr_o}, e);
        end
      end
    end
  end

  task automatic put_cb(input logic [31:0] a, input logic [63:0] link, input logic [31:0] info,
                        input int n, input logic [63:0] st [], input logic [31:0] p []);
    mem[a] = link;
    mem[a + 8] = {32'h0, info};
    for (int k = 0; k < n; k++) begin
      mem[a + 16 + 16 * k] = st[k];
      mem[a + 24 + 16 * k] = {32'h0, p[k]};
    end
  endtask

  task automatic expect_blk(input logic [31:0] a, input logic [15:0] l, input logic [31:0] i);
    exp_q.push_back({i, l, a});
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(posedge clk); #1;
    start_addr_i = a; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_upd(input int target);
    int n = 0;
    while (upd_cnt < target && !err_o && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_err();
    int n = 0;
    while (!err_o && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    done_cnt = 0; upd_cnt = 0;
    exp_q.delete(); req_log.delete(); mem.delete();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "timeout", 80'(cyc), 80'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int sz;
    do_reset();
    // R1 reset state
    check(!mem_req_valid_o, "R1", "req idle", 80'(mem_req_valid_o), 80'h0);
    check(!blk_valid_o, "R1", "blk idle", 80'(blk_valid_o), 80'h0);
    check(!irq_done_o && !irq_update_o, "R1", "irqs low", {irq_done_o, irq_update_o}, 80'h0);
    check(!err_o, "R1", "err low", 80'(err_o), 80'h0);

    // A: two control blocks, injection, consumer stalls
    nblk_cfg_i = 4'd2; extract_i = 1'b0; bp_en = 1'b1;
    put_cb(32'h100, 64'h200, 32'h11, 2, '{64'd64, 64'd40}, '{32'h1000, 32'h1003});
    put_cb(32'h200, EOL, 32'h22, 2, '{64'd100, 64'd8}, '{32'h2000, 32'h2008});
    expect_blk(32'h1000, 16'd64, 32'h11); expect_blk(32'h1003, 16'd40, 32'h11);
    expect_blk(32'h2000, 16'd100, 32'h22); expect_blk(32'h2008, 16'd8, 32'h22);
    pulse_start(32'h100);
    wait_upd(1);
    bp_en = 1'b0;
    check(exp_q.size() == 0, "R3", "all blocks seen, unaligned ok in injection (R9)", 80'(exp_q.size()), 80'h0);
    check(done_cnt == 2, "R5", "done count", 80'(done_cnt), 80'd2);
    check(upd_cnt == 1, "R6", "update at end", 80'(upd_cnt), 80'd1);
    check(req_log.size() == 12, "R4", "reads for 2 blocks x2", 80'(req_log.size()), 80'd12);
    begin
      logic [31:0] ord [6] = '{32'h100, 32'h108, 32'h110, 32'h118, 32'h120, 32'h128};
      for (int k = 0; k < 6; k++)
        check(req_log[k] == ord[k], "R2", "read order", 80'(req_log[k]), 80'(ord[k]));
    end

    // B: append and restart after end of chain
    put_cb(32'h300, EOL, 32'h33, 2, '{64'd256, 64'd128}, '{32'h3000, 32'h3100});
    mem[32'h200] = 64'h300;
    expect_blk(32'h3000, 16'd256, 32'h33); expect_blk(32'h3100, 16'd128, 32'h33);
    sz = req_log.size();
    pulse_start(32'h0);
    wait_upd(2);
    check(req_log[sz] == 32'h200, "R6", "relink read", 80'(req_log[sz]), 80'h200);
    check(exp_q.size() == 0, "R6", "only new blocks", 80'(exp_q.size()), 80'h0);
    check(done_cnt == 3, "R6", "done count", 80'(done_cnt), 80'd3);

    // C: used status word stalls, restart re-reads it
    put_cb(32'h400, EOL, 32'h44, 2, '{64'd16, USED | 64'd24}, '{32'h4000, 32'h4010});
    mem[32'h300] = 64'h400;
    expect_blk(32'h4000, 16'd16, 32'h44);
    pulse_start(32'h0);
    wait_upd(3);
    check(exp_q.size() == 0 && !blk_valid_o, "R7", "stalled before used block", 80'(exp_q.size()), 80'h0);
    check(done_cnt == 3, "R7", "no done while stalled", 80'(done_cnt), 80'd3);
    mem[32'h420] = 64'd24;
    expect_blk(32'h4010, 16'd24, 32'h44);
    sz = req_log.size();
    pulse_start(32'h0);
    wait_upd(4);
    check(req_log[sz] == 32'h420, "R7", "status reread", 80'(req_log[sz]), 80'h420);
    check(exp_q.size() == 0, "R7", "resumed block", 80'(exp_q.size()), 80'h0);
    check(done_cnt == 4, "R5", "done after resume", 80'(done_cnt), 80'd4);

    // D: misaligned link
    mem[32'h400] = 64'h504;
    sz = req_log.size();
    pulse_start(32'h0);
    wait_err();
    check(err_o, "R8", "misaligned link", 80'(err_o), 80'h1);
    check(req_log.size() == sz + 1, "R8", "no read of bad link", 80'(req_log.size()), 80'(sz + 1));

    // E: extraction, bad length
    do_reset();
    check(!err_o, "R1", "err cleared by reset", 80'(err_o), 80'h0);
    nblk_cfg_i = 4'd1; extract_i = 1'b1;
    put_cb(32'h600, EOL, 32'h66, 1, '{64'd200}, '{32'h6000});
    pulse_start(32'h600);
    wait_err();
    check(err_o && exp_q.size() == 0, "R9", "bad extraction length", 80'(err_o), 80'h1);
    check(done_cnt == 0, "R9", "no done on error", 80'(done_cnt), 80'h0);

    // G: extraction, bad pointer
    do_reset();
    put_cb(32'h800, EOL, 32'h88, 1, '{64'd128}, '{32'h8004});
    pulse_start(32'h800);
    wait_err();
    check(err_o, "R9", "bad extraction pointer", 80'(err_o), 80'h1);

    // F: extraction, legal three-block list, stray start mid-walk
    do_reset();
    nblk_cfg_i = 4'd3;
    put_cb(32'h700, EOL, 32'h77, 3, '{64'd128, 64'd384, 64'd256}, '{32'h7000, 32'h7080, 32'h7200});
    expect_blk(32'h7000, 16'd128, 32'h77); expect_blk(32'h7080, 16'd384, 32'h77);
    expect_blk(32'h7200, 16'd256, 32'h77);
    pulse_start(32'h700);
    nblk_cfg_i = 4'd1;
    repeat (2) @(posedge clk);
    pulse_start(32'h900);
    wait_upd(1);
    check(exp_q.size() == 0, "R9", "legal extraction blocks", 80'(exp_q.size()), 80'h0);
    check(done_cnt == 1 && !err_o, "R10", "stray start ignored", 80'(done_cnt), 80'd1);
    check(req_log.size() == 8, "R4", "count sampled at start", 80'(req_log.size()), 80'd8);

    // I: zero blocks per control block
    do_reset();
    nblk_cfg_i = 4'd0; extract_i = 1'b0;
    mem[32'hA00] = EOL; mem[32'hA08] = 64'h0;
    pulse_start(32'hA00);
    wait_upd(1);
    check(done_cnt == 1, "R4", "done with zero blocks", 80'(done_cnt), 80'd1);
    check(req_log.size() == 2, "R4", "two reads only", 80'(req_log.size()), 80'd2);

    // H: misaligned start address
    do_reset();
    nblk_cfg_i = 4'd1;
    pulse_start(32'h902);
    wait_err();
    check(err_o, "R8", "misaligned start", 80'(err_o), 80'h1);
    check(req_log.size() == 0, "R8", "no read issued", 80'(req_log.size()), 80'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule